// File: doc/BRIEF.md
# CPU-Cycle System Timer

This block is a small memory-mapped down-counter timer for an 8-bit processor bus. It keeps a 12-bit count that moves only on CPU-cycle enable pulses, not on every edge of the fast system clock. Software sees the top eight bits of that count, so each visible step is sixteen CPU cycles long. Software writes an 8-bit preset to the count address. It then sets the run bit in the control byte, and the timer counts down to zero. When it reaches zero it stops by itself and can raise a level interrupt request.

The behaviour is set by a three-state machine. `ST_IDLE` is the reset state, and it is also the state after a stop. `ST_COUNT` decrements the counter once per enable. `ST_ZERO` holds the counter at zero after it runs out. The transitions are:
- start: a control write with the run bit set. It moves any state to `ST_COUNT` and reloads the counter.
- stop: a control write with the run bit clear. It moves `ST_COUNT` to `ST_IDLE`.
- expire: the last enabled decrement. It moves `ST_COUNT` to `ST_ZERO`.

Top module: `sys_timer`

## Requirements
- R1: Byte offset 0 is the preset/count register and offset 1 is the control/status register. A read of offset 0 returns bits 11..4 of the down counter.
- R2: While counting, the counter drops by exactly one on each cycle with `cyc_en` high. It holds when `cyc_en` is low.
- R3: A control write with bit 0 = 1 loads the counter with {preset, 4'b1111} and enters counting. This also applies when the timer is already counting, which restarts it.
- R4: A write to offset 0 only stores the preset. It does not change a count that is already in progress.
- R5: When the counter reaches zero, it stays at zero and the run bit reads 0.
- R6: A control write with bit 0 = 0 while counting stops the count. The counter holds its value and the run bit reads 0.
- R7: A read of offset 1 returns the interrupt enable in bit 7, the running state in bit 0, and 0 in bits 6..1.
- R8: `irq_o` rises when the counter reaches zero with the enable set. It stays high until a control write has bit 7 = 0 or bit 0 = 1. A write of 0x80 leaves it high.
- R9: When the counter reaches zero with the enable clear, `irq_o` stays low.
- R10: Reset clears the counter, the preset, the run state, the enable and any pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-clock pulse per CPU cycle |
| bus_sel | input | 1 | Timer window selected |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when no read is selected) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default widths: a 12-bit counter and an 8-bit bus. With these values a full count from preset 0xFF takes 4095 enables, which fits easily in the run. The lowest preset gives a 15-enable run, so the step from one visible value to zero, and the automatic stop, are seen within a few cycles. The table drives both enable settings through mid-count, exact-expiry and over-run cases. Directed tests then cover stop, restart, enable gating, preset writes during a run and the three ways of clearing the interrupt.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ZERO  = 2'd2
    } tmr_state_e;

    localparam logic OFS_COUNT = 1'b0;
    localparam logic OFS_CTRL  = 1'b1;
    localparam int   BIT_RUN   = 0;
endpackage

// File: rtl/systmr_regif.sv
module systmr_regif
    import systmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic              wd_run,
    input  logic              wd_ie,
    input  logic [DATA_W-1:0] cnt_vis,
    input  logic              running,
    input  logic              ie,
    output logic              wr_preset,
    output logic              wr_ctrl,
    output logic              start,
    output logic              stop,
    output logic              irq_clear,
    output logic [DATA_W-1:0] rdata
);
    localparam int BIT_IE = DATA_W - 1;

    logic rd_sel;

    always_comb begin
        wr_preset = bus_sel && bus_we && (bus_addr == OFS_COUNT);
        wr_ctrl   = bus_sel && bus_we && (bus_addr == OFS_CTRL);
        start     = wr_ctrl && wd_run;
        stop      = wr_ctrl && !wd_run;
        irq_clear = wr_ctrl && (wd_run || !wd_ie);
        rd_sel    = bus_sel && !bus_we;
    end

    always_comb begin
        rdata = '0;
        if (rd_sel) begin
            unique case (bus_addr)
                OFS_COUNT: rdata = cnt_vis;
                OFS_CTRL: begin
                    rdata[BIT_IE]  = ie;
                    rdata[BIT_RUN] = running;
                end
                default: rdata = '0;
            endcase
        end
    end

    always_comb begin
        AST_ONE_STROBE: assert ($onehot0({wr_preset, wr_ctrl})); // R1
        AST_START_STOP_EXCL: assert (!(start && stop)); // R3
        if (rd_sel && bus_addr == OFS_CTRL)
            AST_RSVD_ZERO: assert (rdata[BIT_IE-1:1] == '0); // R7
    end
endmodule

// File: rtl/systmr_core.sv
module systmr_core
    import systmr_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              wr_preset,
    input  logic [DATA_W-1:0] preset_wdata,
    input  logic              start,
    input  logic              stop,
    output logic [DATA_W-1:0] cnt_vis,
    output logic              running,
    output logic              expire
);
    localparam int FRAC_W = CNT_W - DATA_W;
    localparam logic [FRAC_W-1:0] FRAC_ONES = '1;
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

    tmr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] preset_q;
    logic              tick, last_tick;

    always_comb begin
        tick      = (state_q == ST_COUNT) && cyc_en && !start && !stop;
        last_tick = tick && (cnt_q <= CNT_ONE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (start)          state_d = ST_COUNT;
                else if (stop)      state_d = ST_IDLE;
                else if (last_tick) state_d = ST_ZERO;
            end
            ST_ZERO: begin
                if (start) state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            preset_q <= '0;
        end else begin
            if (wr_preset) preset_q <= preset_wdata;
            if (start)          cnt_q <= {preset_q, FRAC_ONES};
            else if (last_tick) cnt_q <= '0;
            else if (tick)      cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // outputs
    always_comb begin
        cnt_vis = cnt_q[CNT_W-1:FRAC_W];
        running = (state_q == ST_COUNT);
        expire  = last_tick;
    end

    AST_RUN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == {$past(preset_q), FRAC_ONES}) && running); // R3
    AST_ONE_PER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cyc_en && !start && !stop) |=> cnt_q == $past(cnt_q) - CNT_ONE); // R2
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !start) |=> $stable(cnt_q)); // R2
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ZERO) |-> (cnt_q == '0) && !running); // R5
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && running) |=> !running && $stable(cnt_q)); // R6
    AST_PRESET_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_preset && !cyc_en) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/systmr_irq.sv
module systmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wd_ie,
    input  logic irq_clear,
    input  logic expire,
    output logic ie,
    output logic irq
);
    logic ie_q, pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr_ctrl) ie_q <= wd_ie;
            if (irq_clear)          pend_q <= 1'b0;
            else if (expire && ie_q) pend_q <= 1'b1;
        end
    end

    always_comb begin
        ie  = ie_q;
        irq = pend_q;
    end

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie); // R9
    AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ie && !wr_ctrl) |=> irq); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq); // R8
endmodule

// File: rtl/sys_timer.sv
module sys_timer
    import systmr_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic              wr_preset, wr_ctrl, start, stop, irq_clear;
    logic [DATA_W-1:0] cnt_vis;
    logic              running, expire, ie;

    systmr_regif #(.DATA_W(DATA_W)) u_regif (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wd_run    (bus_wdata[BIT_RUN]),
        .wd_ie     (bus_wdata[DATA_W-1]),
        .cnt_vis   (cnt_vis),
        .running   (running),
        .ie        (ie),
        .wr_preset (wr_preset),
        .wr_ctrl   (wr_ctrl),
        .start     (start),
        .stop      (stop),
        .irq_clear (irq_clear),
        .rdata     (bus_rdata)
    );

    systmr_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_en       (cyc_en),
        .wr_preset    (wr_preset),
        .preset_wdata (bus_wdata),
        .start        (start),
        .stop         (stop),
        .cnt_vis      (cnt_vis),
        .running      (running),
        .expire       (expire)
    );

    systmr_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wd_ie     (bus_wdata[DATA_W-1]),
        .irq_clear (irq_clear),
        .expire    (expire),
        .ie        (ie),
        .irq       (irq_o)
    );

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == OFS_CTRL && bus_wdata[BIT_RUN]) |=> !irq_o); // R8
endmodule

// File: tb/tb_sys_timer.sv
module tb_sys_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    sys_timer dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [7:0]  preset;
        logic        ie;
        logic [11:0] ticks;
        logic [7:0]  exp_cnt;
        logic        exp_run;
        logic        exp_irq;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 1'b1, 12'd14,  8'h00, 1'b1, 1'b0},
        '{8'h00, 1'b1, 12'd15,  8'h00, 1'b0, 1'b1},
        '{8'h03, 1'b0, 12'd16,  8'h02, 1'b1, 1'b0},
        '{8'h03, 1'b0, 12'd63,  8'h00, 1'b0, 1'b0},
        '{8'h10, 1'b1, 12'd20,  8'h0F, 1'b1, 1'b0},
        '{8'hFF, 1'b1, 12'd100, 8'hF9, 1'b1, 1'b0},
        '{8'h01, 1'b1, 12'd40,  8'h00, 1'b0, 1'b1},
        '{8'h05, 1'b0, 12'd0,   8'h05, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cyc_en = 1'b1;
            @(negedge clk); cyc_en = 1'b0;
        end
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(1'b0, v); chk("R10 count after reset", v, 8'h00);
        rd(1'b1, v); chk("R10 ctrl after reset", v, 8'h00);
        chk("R10 irq after reset", {7'b0, irq_o}, 8'h00);

        // table: R1 R2 R3 R5 R8 R9
        for (int k = 0; k < 8; k++) begin
            wr(1'b0, VECS[k].preset);
            wr(1'b1, {VECS[k].ie, 6'b0, 1'b1});
            ticks(int'(VECS[k].ticks));
            rd(1'b0, v); chk($sformatf("R1/R2 vec%0d count", k), v, VECS[k].exp_cnt);
            rd(1'b1, v); chk($sformatf("R5/R7 vec%0d ctrl", k), v, {VECS[k].ie, 6'b0, VECS[k].exp_run});
            chk($sformatf("R8/R9 vec%0d irq", k), {7'b0, irq_o}, {7'b0, VECS[k].exp_irq});
        end

        // R7 reserved bits read zero
        wr(1'b1, 8'h7F);
        rd(1'b1, v); chk("R7 reserved bits", v, 8'h01);

        // R6 stop holds count: preset 2 -> 47, 5 ticks -> 42 (0x2A)
        wr(1'b0, 8'h02); wr(1'b1, 8'h01); ticks(5);
        wr(1'b1, 8'h00);
        ticks(10);
        rd(1'b0, v); chk("R6 count frozen", v, 8'h02);
        rd(1'b1, v); chk("R6 run clear", v, 8'h00);

        // R2 no enable, no movement: preset 0x40 -> 1039, 16 ticks -> 1023 (0x3F)
        wr(1'b0, 8'h40); wr(1'b1, 8'h01); ticks(16);
        repeat (40) @(negedge clk);
        rd(1'b0, v); chk("R2 hold without enable", v, 8'h3F);

        // R4 preset write during run leaves count alone
        wr(1'b0, 8'hAA);
        rd(1'b0, v); chk("R4 count unchanged", v, 8'h3F);
        // R3 restart uses the new preset
        wr(1'b1, 8'h01);
        rd(1'b0, v); chk("R3 restart reload", v, 8'hAA);

        // R8 clearing rules
        wr(1'b0, 8'h00); wr(1'b1, 8'h81); ticks(15);
        chk("R8 irq raised", {7'b0, irq_o}, 8'h01);
        wr(1'b1, 8'h80);
        chk("R8 irq kept by 0x80", {7'b0, irq_o}, 8'h01);
        wr(1'b1, 8'h00);
        chk("R8 irq cleared by ie=0", {7'b0, irq_o}, 8'h00);
        wr(1'b1, 8'h81); ticks(15);
        chk("R8 irq raised again", {7'b0, irq_o}, 8'h01);
        wr(1'b1, 8'h81);
        chk("R8 irq cleared by restart", {7'b0, irq_o}, 8'h00);

        // R10 reset mid-run
        wr(1'b0, 8'h33); wr(1'b1, 8'h81); ticks(3);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(1'b0, v); chk("R10 count after mid-run reset", v, 8'h00);
        rd(1'b1, c); chk("R10 ctrl after mid-run reset", c, 8'h00);
        wr(1'b1, 8'h01);
        rd(1'b0, v); chk("R10 preset cleared", v, 8'h00);

        finish_run();
    end
endmodule